// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit sits beside an I2C bus engine and turns the engine's single-cycle event pulses into sticky status flags. Software reads and clears those flags through a 16-bit register interface. A mask register selects which flags may raise the one interrupt line. A vector register returns a small code for the most urgent enabled event that is still pending.

Reading the vector is destructive. It returns the code and, on the same clock edge, clears the flag behind it, so an interrupt handler can loop on vector reads until it sees code 0. Two flags have an extra clear source. The receive-ready flag drops when the data path reports that the receive data register was read. The transmit-ready flag drops when the data path reports that the transmit data register was written. Two further status bits are not latched; they mirror the live bus-busy level and the receive-shift-full level.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset the mask register and all latched status flags are 0, `irq` is low and the vector register reads 0.
- R2: An event pulse sets its status flag, visible from the next cycle, at these bit positions of the status register (offset 0x08): arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed as slave 9.
- R3: A write to the status register clears each flag whose bit is written 1 and leaves flags written 0 unchanged. An event arriving in the same cycle as the clearing write wins, and its flag stays set.
- R4: Status bit 12 shows the live `bus_busy` level and bit 11 shows the live `rx_shift_full` level. Writes to these bits have no effect.
- R5: The mask register at offset 0x04 holds enable bits 0..6, in the same event order as the vector codes minus one (arbitration lost 0 through addressed as slave 6). It reads back what was written, and bits 15..7 read 0.
- R6: The vector register at offset 0x28 returns the lowest code among pending, enabled events. The codes are 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop detected and 7 addressed as slave. It returns 0 when none is pending. A pending flag whose mask bit is 0 is never reported.
- R7: Reading the vector register clears the flag whose code it returned, so the next read returns the next pending code. Flags that are masked out stay set.
- R8: `irq` is high exactly when at least one status flag with its mask bit set is pending.
- R9: A pulse on `rx_data_taken` clears the receive-ready flag. A pulse on `tx_data_loaded` clears the transmit-ready flag. No other flag is affected.
- R10: Offsets other than 0x04, 0x08 and 0x28 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_arb_lost | input | 1 | Arbitration-lost event pulse |
| ev_nack | input | 1 | No-acknowledge event pulse |
| ev_acc_rdy | input | 1 | Access-ready event pulse |
| ev_rx_rdy | input | 1 | Receive-ready event pulse |
| ev_tx_rdy | input | 1 | Transmit-ready event pulse |
| ev_stop | input | 1 | Stop-detected event pulse |
| ev_slave_addr | input | 1 | Addressed-as-slave event pulse |
| bus_busy | input | 1 | Live bus-busy level |
| rx_shift_full | input | 1 | Live receive-shift-full level |
| rx_data_taken | input | 1 | Receive data register was read |
| tx_data_loaded | input | 1 | Transmit data register was written |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects only) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request level |

## Verification
The bench sweeps all 128 combinations of simultaneous event pulses against four mask patterns: all enabled, none enabled, and two alternating halves. The alternating masks separate a correct priority order from one that ignores the mask. For each combination it checks the placement of every status bit and the `irq` level. It then drains the vector one read at a time and compares each code with the lowest enabled pending event, which tells destructive reads apart from non-destructive ones and shows whether masked flags survive the drain. Directed cases cover a clearing write that collides with a new event, writes of 0, the live level bits, the two data-path clears and unmapped offsets.

// File: rtl/i2civ_pkg.sv
package i2civ_pkg;

  localparam int unsigned NUM_EV = 7;

  typedef enum logic [2:0] {
    VEC_NONE   = 3'd0,
    VEC_ARB    = 3'd1,
    VEC_NACK   = 3'd2,
    VEC_ACCRDY = 3'd3,
    VEC_RXRDY  = 3'd4,
    VEC_TXRDY  = 3'd5,
    VEC_STOP   = 3'd6,
    VEC_SLAVE  = 3'd7
  } vec_code_e;

  localparam int unsigned IDX_RXRDY = 3;
  localparam int unsigned IDX_TXRDY = 4;
  localparam int unsigned POS_RSFULL = 11;
  localparam int unsigned POS_BUSY   = 12;

  // Status bit position of event index idx (code - 1).
  function automatic int unsigned stat_pos(input int unsigned idx);
    return (idx == 6) ? 9 : idx;
  endfunction

  // Code of the lowest set bit, 0 when none.
  function automatic logic [2:0] lowest_code(input logic [NUM_EV-1:0] pend);
    logic [2:0] c;
    c = 3'd0;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (pend[i]) c = 3'(i + 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/i2civ_flag_bank.sv
module i2civ_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flags_o[i] = q;

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_o[i]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
  end

endmodule

// File: rtl/i2civ_prio.sv
module i2civ_prio
  import i2civ_pkg::*;
#(
  parameter int unsigned N = NUM_EV
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] sel_o,
  output logic [2:0]   code_o
);

  logic [N-1:0] seen;

  for (genvar i = 0; i < N; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign seen[i]  = pend_i[i];
      assign sel_o[i] = pend_i[i];
    end else begin : g_rest
      assign seen[i]  = seen[i-1] | pend_i[i];
      assign sel_o[i] = pend_i[i] & ~seen[i-1];
    end
  end

  assign code_o = lowest_code(pend_i);

  assert_onehot_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));
  assert_code_matches_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != 3'd0) == (|sel_o));

endmodule

// File: rtl/i2civ_regif.sv
module i2civ_regif #(
  parameter int unsigned   AW       = 6,
  parameter int unsigned   DW       = 16,
  parameter int unsigned   MW       = 7,
  parameter logic [AW-1:0] MASK_OFS = 6'h04,
  parameter logic [AW-1:0] STAT_OFS = 6'h08,
  parameter logic [AW-1:0] VEC_OFS  = 6'h28
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [MW-1:0] mask_i,
  input  logic [DW-1:0] status_i,
  input  logic [2:0]    code_i,
  output logic          wr_mask_o,
  output logic          wr_stat_o,
  output logic          rd_vec_o,
  output logic [DW-1:0] rdata_o
);

  logic hit_mask, hit_stat, hit_vec;

  assign hit_mask  = (addr_i == MASK_OFS);
  assign hit_stat  = (addr_i == STAT_OFS);
  assign hit_vec   = (addr_i == VEC_OFS);
  assign wr_mask_o = wr_i & hit_mask;
  assign wr_stat_o = wr_i & hit_stat;
  assign rd_vec_o  = rd_i & hit_vec;

  always_comb begin
    rdata_o = '0;
    if (hit_mask)      rdata_o = DW'(mask_i);
    else if (hit_stat) rdata_o = status_i;
    else if (hit_vec)  rdata_o = DW'(code_i);
  end

endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import i2civ_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_arb_lost,
  input  logic          ev_nack,
  input  logic          ev_acc_rdy,
  input  logic          ev_rx_rdy,
  input  logic          ev_tx_rdy,
  input  logic          ev_stop,
  input  logic          ev_slave_addr,
  input  logic          bus_busy,
  input  logic          rx_shift_full,
  input  logic          rx_data_taken,
  input  logic          tx_data_loaded,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);

  localparam int unsigned N = NUM_EV;

  logic [N-1:0]  ev, mask_q, flags, pend, sel, w1c, vec_clr, auto_clr, clr;
  logic [2:0]    code;
  logic          wr_mask_en, wr_stat_en, rd_vec_en;
  logic [DW-1:0] status_word;
  logic          unused_wdata;

  assign ev = {ev_slave_addr, ev_stop, ev_tx_rdy, ev_rx_rdy,
               ev_acc_rdy, ev_nack, ev_arb_lost};

  i2civ_regif #(.AW(AW), .DW(DW), .MW(N)) u_regif (
    .addr_i   (reg_addr),
    .wr_i     (reg_wr),
    .rd_i     (reg_rd),
    .mask_i   (mask_q),
    .status_i (status_word),
    .code_i   (code),
    .wr_mask_o(wr_mask_en),
    .wr_stat_o(wr_stat_en),
    .rd_vec_o (rd_vec_en),
    .rdata_o  (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          mask_q <= '0;
    else if (wr_mask_en) mask_q <= reg_wdata[N-1:0];
  end

  // Clear sources per flag.
  for (genvar i = 0; i < N; i++) begin : g_clr
    assign w1c[i] = wr_stat_en & reg_wdata[stat_pos(i)];
    if (i == IDX_RXRDY) begin : g_rx
      assign auto_clr[i] = rx_data_taken;
    end else if (i == IDX_TXRDY) begin : g_tx
      assign auto_clr[i] = tx_data_loaded;
    end else begin : g_none
      assign auto_clr[i] = 1'b0;
    end
  end
  assign vec_clr = rd_vec_en ? sel : '0;
  assign clr     = w1c | vec_clr | auto_clr;

  i2civ_flag_bank #(.N(N)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ev),
    .clr_i  (clr),
    .flags_o(flags)
  );

  assign pend = flags & mask_q;

  i2civ_prio #(.N(N)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .pend_i(pend),
    .sel_o (sel),
    .code_o(code)
  );

  always_comb begin
    status_word = '0;
    for (int i = 0; i < N; i++) status_word[stat_pos(i)] = flags[i];
    status_word[POS_RSFULL] = rx_shift_full;
    status_word[POS_BUSY]   = bus_busy;
  end

  assign irq = |pend;

  assign unused_wdata = ^reg_wdata;

  assert_irq_follows_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(ev & mask_q)) && !wr_mask_en) |=> irq);
  assert_irq_vector_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != 3'd0));
  assert_vector_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec_en && (|sel) && !(|(ev & sel))) |=> ((flags & $past(sel)) == '0));
  assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_en |=> (mask_q == $past(reg_wdata[N-1:0])));
  assert_masked_not_reported_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code != 3'd0) |-> mask_q[code - 3'd1]);

endmodule

// File: tb/i2c_irq_vector_tb.sv
module i2c_irq_vector_tb;

  localparam logic [5:0] A_MASK = 6'h04;
  localparam logic [5:0] A_STAT = 6'h08;
  localparam logic [5:0] A_VEC  = 6'h28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] ev = '0;
  logic bus_busy = 1'b0, rx_shift_full = 1'b0;
  logic rx_data_taken = 1'b0, tx_data_loaded = 1'b0;
  logic [5:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_irq_vector u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]),
    .ev_rx_rdy(ev[3]), .ev_tx_rdy(ev[4]), .ev_stop(ev[5]),
    .ev_slave_addr(ev[6]),
    .bus_busy(bus_busy), .rx_shift_full(rx_shift_full),
    .rx_data_taken(rx_data_taken), .tx_data_loaded(tx_data_loaded),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // Expected status word from an event pattern (bit 6 moves to 9).
  function automatic logic [15:0] place(input logic [6:0] p);
    logic [15:0] r;
    r = 16'h0000;
    r[9] = p[6];
    r[5:0] = p[5:0];
    r[11] = rx_shift_full;
    r[12] = bus_busy;
    return r;
  endfunction

  function automatic logic [15:0] first_code(input logic [6:0] p);
    for (int k = 0; k < 7; k++) if (p[k]) return 16'(k + 1);
    return 16'd0;
  endfunction

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] p);
    @(negedge clk);
    ev = p;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] d;
    logic [6:0] masks [4];
    masks[0] = 7'h7F; masks[1] = 7'h00; masks[2] = 7'h55; masks[3] = 7'h2A;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 16'(irq), 16'h0);
    rd(A_MASK, d); chk("R1 mask", d, 16'h0);
    rd(A_STAT, d); chk("R1 status", d, 16'h0);
    rd(A_VEC, d);  chk("R1 vector", d, 16'h0);

    // R10 unmapped offsets
    wr(6'h00, 16'hFFFF);
    rd(6'h00, d); chk("R10 offset 0x00", d, 16'h0);
    rd(6'h2C, d); chk("R10 offset 0x2C", d, 16'h0);
    rd(A_MASK, d); chk("R10 mask untouched", d, 16'h0);

    // R5 mask readback, upper bits read 0
    wr(A_MASK, 16'hFFAB);
    rd(A_MASK, d); chk("R5 mask readback", d, 16'h002B);

    // Exhaustive sweep: R2 R6 R7 R8
    foreach (masks[mi]) begin
      wr(A_MASK, 16'(masks[mi]));
      for (int p = 0; p < 128; p++) begin
        logic [6:0] pend;
        wr(A_STAT, 16'hFFFF);
        pulse(7'(p));
        #1 chk("R8 irq level", 16'(irq), 16'(|(7'(p) & masks[mi])));
        rd(A_STAT, d); chk("R2 status placement", d, place(7'(p)));
        pend = 7'(p) & masks[mi];
        for (int n = 0; n < 8; n++) begin
          logic [15:0] e;
          e = first_code(pend);
          rd(A_VEC, d); chk("R6 R7 vector drain", d, e);
          if (e != 0) pend[e - 1] = 1'b0;
        end
        #1 chk("R8 irq after drain", 16'(irq), 16'h0);
        rd(A_STAT, d); chk("R7 masked flags remain", d, place(7'(p) & ~masks[mi]));
      end
    end

    // R3 w1c with zero leaves flags; collision with a new event
    wr(A_MASK, 16'h0000);
    wr(A_STAT, 16'hFFFF);
    pulse(7'h07);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, d); chk("R3 write 0 keeps", d, 16'h0007);
    wr(A_STAT, 16'h0002);
    rd(A_STAT, d); chk("R3 write 1 clears", d, 16'h0005);
    @(negedge clk);
    ev = 7'h04; reg_addr = A_STAT; reg_wdata = 16'h0004; reg_wr = 1'b1;
    @(negedge clk);
    ev = '0; reg_wr = 1'b0;
    rd(A_STAT, d); chk("R3 event beats clear", d, 16'h0005);

    // R4 live levels, not writable
    wr(A_STAT, 16'hFFFF);
    bus_busy = 1'b1;
    rd(A_STAT, d); chk("R4 busy live", d, 16'h1000);
    rx_shift_full = 1'b1;
    wr(A_STAT, 16'h1800);
    rd(A_STAT, d); chk("R4 levels not cleared", d, 16'h1800);
    bus_busy = 1'b0; rx_shift_full = 1'b0;
    rd(A_STAT, d); chk("R4 levels follow", d, 16'h0000);

    // R9 data-path clears
    pulse(7'h19);
    @(negedge clk); rx_data_taken = 1'b1;
    @(negedge clk); rx_data_taken = 1'b0;
    rd(A_STAT, d); chk("R9 rx ready cleared", d, 16'h0011);
    @(negedge clk); tx_data_loaded = 1'b1;
    @(negedge clk); tx_data_loaded = 1'b0;
    rd(A_STAT, d); chk("R9 tx ready cleared", d, 16'h0001);

    // R8 enabling the mask afterwards raises irq
    wr(A_MASK, 16'h0001);
    #1 chk("R8 irq on mask enable", 16'(irq), 16'h1);
    rd(A_VEC, d); chk("R6 vector after mask", d, 16'h1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule